// File: doc/BRIEF.md
# Video capture lane mapper

This block sits between the colour and sync pins of a retro computer's video chip and a pixel capture engine. Each sample carries three 4-bit colour lane groups. The block rewires and widens them according to one of five sampling modes, and emits a fixed 12-bit pixel word laid out as `{R[3:0], G[3:0], B[3:0]}`, with the MSB on the left. It also forms a composite sync from the separate horizontal and vertical sync pins. It can force pixels to black, either from a dedicated blanking pin or, in one mode, from the spare blue lane bit.

A mono-detect pin turns on a pairing stage. This stage gathers two consecutive mono pixels into one word, carrying them on the top red and top green lane bits. In the mono pairing mode, each such word is expanded back into two full-scale grey pixels. A new mode request is adopted only at a rising vertical sync edge, so a frame never mixes two layouts.

The data path is a stream with a valid strobe on each side and no ready. Video cannot be stalled, so there is no back-pressure: the sink must accept every cycle in which `pix_valid` is high. In mono pairing mode with mono-detect low, the source must leave at least one idle cycle between valid samples.

Top module: `vcl_lane_mapper`

## Requirements
- R1: After reset the active mode is 12-bit (code 2). In 12-bit mode a valid sample appears two clock edges later on `pix` as `{lane_r, lane_g, lane_b}`, unchanged.
- R2: In mode code 0, each colour uses lane bits 2..0. It is widened to 4 bits by appending bit 2 as the new LSB, so 3'b111 gives 15 and 3'b000 gives 0.
- R3: In mode code 1, each colour uses lane bits 3..1 and is widened in the same way as R2.
- R4: In mode code 3, colour is taken as in R2, and `lane_b[3]` high forces the pixel to 12'h000.
- R5: A sample with `blank_in` high produces 12'h000 in every mode. In mono pairing mode, both of that word's pixels are 12'h000.
- R6: `csync` equals `hsync_in ^ vsync_in`, registered one edge later.
- R7: `mode_sel` is adopted only at an edge where `vsync_in` is sampled high after being low. A sample taken at that edge still uses the old mode. Codes 5 to 7 are ignored and the active mode is kept.
- R8: While `mono_det` is high, valid samples pair up. The first sample's `mono_bit` becomes R3 and the second's becomes G3. All other bits come from the second sample, and one word is emitted per pair. A held half-pair is dropped at a rising vertical sync edge or when `mono_det` is low.
- R9: In mode code 4, each word yields two pixels on consecutive edges: first the R3 bit, then the G3 bit. Each pixel is 12'hFFF for a 1 and 12'h000 for a 0.
- R10: During reset, `pix_valid`, `pix` and `csync` are 0.
- R11: `pix_valid` is high only on edges that carry a pixel derived from a valid sample, as described in R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane sample present this cycle |
| lane_r | input | 4 | Red lane group |
| lane_g | input | 4 | Green lane group |
| lane_b | input | 4 | Blue lane group |
| blank_in | input | 1 | Force sample to black |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync; its rising edge adopts a new mode |
| mono_bit | input | 1 | Monochrome video bit |
| mono_det | input | 1 | Enables mono pixel pairing |
| mode_sel | input | 3 | Requested sampling mode (0 to 4) |
| pix_valid | output | 1 | Pixel strobe |
| pix | output | 12 | Pixel `{R,G,B}` |
| csync | output | 1 | Composite sync |

## Verification
The assertions take for granted that, in mono pairing mode, a decoded word never arrives while the second pixel of the previous word is still pending. That holds when mono-detect pairs the samples, or when valid samples are spaced at least two cycles apart. The stimulus keeps to this rule: it drives valid on every cycle only when mono-detect is high, and leaves gaps otherwise. The assertions also assume reset is held from time zero. Mode requests are presented some cycles before the vertical sync pulse that adopts them, and the bench also probes the cycles before that edge.

// File: rtl/vcl_pkg.sv
package vcl_pkg;

  typedef enum logic [2:0] {
    MD_NINE_LO     = 3'd0,
    MD_NINE_HI     = 3'd1,
    MD_TWELVE      = 3'd2,
    MD_NINE_LO_BLK = 3'd3,
    MD_MONO_PAIR   = 3'd4
  } vcl_mode_e;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/vcl_mode_reg.sv
module vcl_mode_reg
  import vcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [MODE_W-1:0] mode_req,
  output logic              vs_rise,
  output vcl_mode_e         mode_act,
  output logic              csync
);

  logic vs_q;
  logic req_ok;

  always_comb begin
    vs_rise = vsync_in & ~vs_q;
    req_ok  = (mode_req <= MODE_W'(MD_MONO_PAIR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q     <= 1'b0;
      mode_act <= MD_TWELVE;
      csync    <= 1'b0;
    end else begin
      vs_q  <= vsync_in;
      csync <= hsync_in ^ vsync_in;
      if (vs_rise && req_ok) mode_act <= vcl_mode_e'(mode_req);
    end
  end

  // R7: mode only moves on a vertical sync rising edge
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync_in && !vs_q) |=> $stable(mode_act));

  // R7: active mode always a defined code
  p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_act inside {MD_NINE_LO, MD_NINE_HI, MD_TWELVE, MD_NINE_LO_BLK, MD_MONO_PAIR});

  // R6: composite sync follows the sync pins one edge later
  p_csync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> csync == $past(hsync_in ^ vsync_in));

endmodule

// File: rtl/vcl_pair_pack.sv
module vcl_pair_pack
  import vcl_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CH_W-1:0] lane_r,
  input  logic [CH_W-1:0] lane_g,
  input  logic [CH_W-1:0] lane_b,
  input  logic            blank_in,
  input  logic            mono_bit,
  input  logic            mono_det,
  input  logic            vs_rise,
  input  vcl_mode_e       mode_act,
  output logic            w_valid,
  output logic [CH_W-1:0] w_r,
  output logic [CH_W-1:0] w_g,
  output logic [CH_W-1:0] w_b,
  output logic            w_blank,
  output vcl_mode_e       w_mode
);

  logic            half_q;
  logic            hold_q;
  logic            half_eff;
  logic            emit;
  logic            start_pair;
  logic [CH_W-1:0] r_m;
  logic [CH_W-1:0] g_m;

  always_comb begin
    half_eff   = half_q & ~vs_rise;
    emit       = in_valid & (~mono_det | half_eff);
    start_pair = in_valid & mono_det & ~half_eff;
    if (mono_det) begin
      r_m = {hold_q,   lane_r[CH_W-2:0]};
      g_m = {mono_bit, lane_g[CH_W-2:0]};
    end else begin
      r_m = lane_r;
      g_m = lane_g;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      hold_q  <= 1'b0;
      w_valid <= 1'b0;
      w_r     <= '0;
      w_g     <= '0;
      w_b     <= '0;
      w_blank <= 1'b0;
      w_mode  <= MD_TWELVE;
    end else begin
      w_valid <= emit;
      if (emit) begin
        w_r     <= r_m;
        w_g     <= g_m;
        w_b     <= lane_b;
        w_blank <= blank_in;
        w_mode  <= mode_act;
      end
      if (!mono_det)      half_q <= 1'b0;
      else if (in_valid)  half_q <= ~half_eff;
      else if (vs_rise)   half_q <= 1'b0;
      if (start_pair) hold_q <= mono_bit;
    end
  end

  // R11: a word only ever follows an accepted sample
  p_word_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> $past(in_valid));

  // R8: pairing state never survives mono-detect going low
  p_pair_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mono_det |=> !half_q);

endmodule

// File: rtl/vcl_lane_decode.sv
module vcl_lane_decode
  import vcl_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                w_valid,
  input  logic [CH_W-1:0]     w_r,
  input  logic [CH_W-1:0]     w_g,
  input  logic [CH_W-1:0]     w_b,
  input  logic                w_blank,
  input  vcl_mode_e           w_mode,
  output logic                pix_valid,
  output logic [3*CH_W-1:0]   pix
);

  localparam int unsigned PIX_W = 3 * CH_W;
  localparam int unsigned LO_W  = CH_W - 1;

  function automatic logic [CH_W-1:0] widen(input logic [LO_W-1:0] x);
    return {x, x[LO_W-1]};
  endfunction

  logic [PIX_W-1:0] col;
  logic [PIX_W-1:0] grey_a;
  logic [PIX_W-1:0] grey_b;
  logic             blank_eff;
  logic             is_mono;
  logic             pend_q;
  logic [PIX_W-1:0] pend_pix;

  always_comb begin
    blank_eff = w_blank;
    case (w_mode)
      MD_NINE_LO:
        col = {widen(w_r[LO_W-1:0]), widen(w_g[LO_W-1:0]), widen(w_b[LO_W-1:0])};
      MD_NINE_HI:
        col = {widen(w_r[CH_W-1:1]), widen(w_g[CH_W-1:1]), widen(w_b[CH_W-1:1])};
      MD_NINE_LO_BLK: begin
        col       = {widen(w_r[LO_W-1:0]), widen(w_g[LO_W-1:0]), widen(w_b[LO_W-1:0])};
        blank_eff = w_blank | w_b[CH_W-1];
      end
      default:
        col = {w_r, w_g, w_b};
    endcase
    is_mono = (w_mode == MD_MONO_PAIR);
    grey_a  = {PIX_W{w_r[CH_W-1]}};
    grey_b  = {PIX_W{w_g[CH_W-1]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix       <= '0;
      pend_q    <= 1'b0;
      pend_pix  <= '0;
    end else if (w_valid) begin
      pix_valid <= 1'b1;
      if (is_mono) begin
        pix      <= blank_eff ? '0 : grey_a;
        pend_pix <= blank_eff ? '0 : grey_b;
        pend_q   <= 1'b1;
      end else begin
        pix    <= blank_eff ? '0 : col;
        pend_q <= 1'b0;
      end
    end else if (pend_q) begin
      pix_valid <= 1'b1;
      pix       <= pend_pix;
      pend_q    <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
    end
  end

  // R9: second grey pixel slot is never overrun by a new word
  p_pend_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !w_valid);

  // R9: the held second pixel always follows the first
  p_pend_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> pix_valid);

  // R5: a blanked word always comes out black
  p_blank_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_blank) |=> pix == '0);

endmodule

// File: rtl/vcl_lane_mapper.sv
module vcl_lane_mapper
  import vcl_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CH_W-1:0]     lane_r,
  input  logic [CH_W-1:0]     lane_g,
  input  logic [CH_W-1:0]     lane_b,
  input  logic                blank_in,
  input  logic                hsync_in,
  input  logic                vsync_in,
  input  logic                mono_bit,
  input  logic                mono_det,
  input  logic [MODE_W-1:0]   mode_sel,
  output logic                pix_valid,
  output logic [3*CH_W-1:0]   pix,
  output logic                csync
);

  logic            vs_rise;
  vcl_mode_e       mode_act;
  logic            w_valid;
  logic [CH_W-1:0] w_r;
  logic [CH_W-1:0] w_g;
  logic [CH_W-1:0] w_b;
  logic            w_blank;
  vcl_mode_e       w_mode;

  vcl_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_in (hsync_in),
    .vsync_in (vsync_in),
    .mode_req (mode_sel),
    .vs_rise  (vs_rise),
    .mode_act (mode_act),
    .csync    (csync)
  );

  vcl_pair_pack #(.CH_W(CH_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .lane_r   (lane_r),
    .lane_g   (lane_g),
    .lane_b   (lane_b),
    .blank_in (blank_in),
    .mono_bit (mono_bit),
    .mono_det (mono_det),
    .vs_rise  (vs_rise),
    .mode_act (mode_act),
    .w_valid  (w_valid),
    .w_r      (w_r),
    .w_g      (w_g),
    .w_b      (w_b),
    .w_blank  (w_blank),
    .w_mode   (w_mode)
  );

  vcl_lane_decode #(.CH_W(CH_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .w_valid   (w_valid),
    .w_r       (w_r),
    .w_g       (w_g),
    .w_b       (w_b),
    .w_blank   (w_blank),
    .w_mode    (w_mode),
    .pix_valid (pix_valid),
    .pix       (pix)
  );

  // R11: no pixel strobe may appear without an earlier sample
  p_valid_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !$past(pix_valid)) |-> $past(w_valid));

endmodule

// File: tb/vcl_lane_mapper_tb.sv
module vcl_lane_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, blank_in, hsync_in, vsync_in, mono_bit, mono_det;
  logic [3:0]  lane_r, lane_g, lane_b;
  logic [2:0]  mode_sel;
  logic        pix_valid, csync;
  logic [11:0] pix;

  always #4 clk = ~clk;

  vcl_lane_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lane_r(lane_r), .lane_g(lane_g), .lane_b(lane_b),
    .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .mono_bit(mono_bit), .mono_det(mono_det), .mode_sel(mode_sel),
    .pix_valid(pix_valid), .pix(pix), .csync(csync)
  );

  int ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  int          q_due[$];
  logic [11:0] q_val[$];
  string       q_tag[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  int    m_act = 2;
  bit    prev_vs = 0, half = 0, hbit = 0;
  bit    exp_cs = 0, cs_armed = 0;
  bit    cur_hs = 0, cur_vs = 0, cur_md = 0;
  int    cur_ms = 2;
  int    hs_ctr = 0;
  string sec = "R1";
  logic [11:0] rnd = 12'hACE;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] w3(input logic [2:0] x);
    return {x, x[2]};
  endfunction

  function automatic logic [11:0] ref_pix(input int md, input logic [3:0] r, g, b,
                                          input bit blk);
    if (blk) return 12'h000;
    case (md)
      0: return {w3(r[2:0]), w3(g[2:0]), w3(b[2:0])};
      1: return {w3(r[3:1]), w3(g[3:1]), w3(b[3:1])};
      3: return b[3] ? 12'h000 : {w3(r[2:0]), w3(g[2:0]), w3(b[2:0])};
      default: return {r, g, b};
    endcase
  endfunction

  task automatic push(input int due, input logic [11:0] v);
    q_due.push_back(due);
    q_val.push_back(v);
    q_tag.push_back(sec);
  endtask

  task automatic observe();
    while (q_due.size() > 0 && q_due[0] < ecount) begin
      chk(0, q_tag[0], "missed pixel", 0, q_val[0]);
      void'(q_due.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
    if (q_due.size() > 0 && q_due[0] == ecount) begin
      chk(pix_valid === 1'b1 && pix === q_val[0], q_tag[0], "pixel",
          {pix_valid, pix}, {1'b1, q_val[0]});
      void'(q_due.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end else begin
      chk(pix_valid === 1'b0, "R11", "idle strobe", pix_valid, 0);
    end
    if (cs_armed) chk(csync === exp_cs, "R6", "csync", csync, exp_cs);
  endtask

  task automatic step(input logic [3:0] r, g, b, input bit v, blk, mb);
    int p;
    int mode_use;
    bit vs_rise, emit;
    logic [3:0] rr, gg;
    @(negedge clk);
    observe();
    hs_ctr++;
    if (hs_ctr % 5 == 0) cur_hs = ~cur_hs;
    lane_r = r; lane_g = g; lane_b = b; in_valid = v; blank_in = blk;
    mono_bit = mb; hsync_in = cur_hs; vsync_in = cur_vs; mono_det = cur_md;
    mode_sel = 3'(cur_ms);
    p = ecount;
    exp_cs = cur_hs ^ cur_vs; cs_armed = 1;
    vs_rise = cur_vs && !prev_vs;
    mode_use = m_act;
    if (vs_rise && cur_ms < 5) m_act = cur_ms;
    prev_vs = cur_vs;
    if (vs_rise) half = 0;
    emit = 0; rr = r; gg = g;
    if (!cur_md) begin
      half = 0; emit = v;
    end else if (v) begin
      if (!half) begin half = 1; hbit = mb; end
      else begin half = 0; rr[3] = hbit; gg[3] = mb; emit = 1; end
    end
    if (emit) begin
      if (mode_use == 4) begin
        push(p + 2, blk ? 12'h000 : (rr[3] ? 12'hFFF : 12'h000));
        push(p + 3, blk ? 12'h000 : (gg[3] ? 12'hFFF : 12'h000));
      end else begin
        push(p + 2, ref_pix(mode_use, rr, gg, b, blk));
      end
    end
  endtask

  task automatic rstep(input bit v, blk);
    rnd = {rnd[10:0], rnd[11] ^ rnd[5] ^ rnd[3] ^ rnd[0]};
    step(rnd[11:8], rnd[7:4], rnd[3:0], v, blk, rnd[2]);
  endtask

  task automatic vpulse(input int ms);
    cur_ms = ms;
    rstep(0, 0);
    cur_vs = 1;
    rstep(1, 0);
    cur_vs = 0;
    rstep(0, 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; blank_in = 0; hsync_in = 0; vsync_in = 0;
    mono_bit = 0; mono_det = 0; mode_sel = 3'd2;
    lane_r = 0; lane_g = 0; lane_b = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(pix_valid === 1'b0, "R10", "reset strobe", pix_valid, 0);
    chk(pix === 12'h000, "R10", "reset pixel", pix, 0);
    chk(csync === 1'b0, "R10", "reset csync", csync, 0);
    rst_n = 1;

    // R1 / R11: default 12-bit pass-through with gaps
    sec = "R1";
    for (int i = 0; i < 12; i++) rstep(i % 3 != 0, 0);

    // R7: request held back until the vertical sync edge
    sec = "R7"; cur_ms = 0;
    for (int i = 0; i < 4; i++) rstep(1, 0);
    cur_vs = 1; rstep(1, 0); cur_vs = 0;

    // R2: low three bits, top bit replicated
    sec = "R2";
    step(4'h7, 4'h0, 4'hD, 1, 0, 0);
    step(4'h8, 4'hF, 4'h4, 1, 0, 0);
    for (int i = 0; i < 6; i++) rstep(1, 0);

    // R3: high three bits
    vpulse(1); sec = "R3";
    step(4'hF, 4'h1, 4'h8, 1, 0, 0);
    step(4'hE, 4'h6, 4'h3, 1, 0, 0);
    for (int i = 0; i < 6; i++) rstep(i % 2 == 0, 0);

    // R4: B3 blanks in mode 3
    vpulse(3); sec = "R4";
    step(4'h7, 4'h7, 4'h7, 1, 0, 0);
    step(4'h7, 4'h7, 4'hF, 1, 0, 0);
    for (int i = 0; i < 6; i++) rstep(1, 0);

    // R7: illegal code ignored, mode 3 kept
    vpulse(6); sec = "R7";
    step(4'h5, 4'h2, 4'h8, 1, 0, 0);
    step(4'h5, 4'h2, 4'h1, 1, 0, 0);

    // R5: blank pin in two modes
    sec = "R5";
    step(4'hF, 4'hF, 4'h7, 1, 1, 0);
    vpulse(2); sec = "R5";
    for (int i = 0; i < 6; i++) rstep(1, i % 2 == 0);

    // R8: pairing in 12-bit mode, then cut short by mono_det and vsync
    sec = "R8"; cur_md = 1;
    step(4'h0, 4'h0, 4'h3, 1, 0, 1);
    step(4'h1, 4'h2, 4'h3, 1, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 0, 0);
    step(4'h5, 4'h6, 4'h7, 1, 0, 1);
    for (int i = 0; i < 6; i++) rstep(1, 0);
    rstep(1, 0);
    cur_md = 0; rstep(0, 0); cur_md = 1;
    for (int i = 0; i < 4; i++) rstep(1, 0);
    rstep(1, 0);
    vpulse(2); sec = "R8";
    for (int i = 0; i < 4; i++) rstep(1, 0);

    // R9: mono pairing mode, two grey pixels per word
    vpulse(4); sec = "R9";
    step(4'h0, 4'h0, 4'h0, 1, 0, 1);
    step(4'h0, 4'h0, 4'h0, 1, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 0, 1);
    for (int i = 0; i < 16; i++) rstep(1, i == 7);
    cur_md = 0;
    for (int i = 0; i < 8; i++) rstep(i % 2 == 0, 0);

    sec = "R11";
    for (int i = 0; i < 6; i++) rstep(0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", ecount, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule